// File: doc/BRIEF.md
# Serial-to-Parallel Deserializer with Word-Boundary Slip

This block turns a serial bit stream into 8-bit parallel words. Every clock cycle in which the enable is high, it captures one bit in single-rate mode or two bits in double-rate mode. Double-rate capture is modelled as a two-bit lane per cycle, so all logic runs on one clock edge. Every eighth accepted bit closes a word. The block then presents that word on the parallel output with a one-cycle valid pulse. The word-completion edge is the block's word-rate timing point, so the word "clock" is an enable derived from the bit count.

To align a receiver to a training pattern, the user asserts the slip input until the expected pattern appears on the output. Each accepted slip moves the word boundary. In single-rate mode the output rotates left by one bit. In double-rate mode successive slips alternate between two shift amounts. In both modes, repeated slips reach every rotation of a repeating 8-bit pattern. After an accepted slip, requests are locked out for two word periods, so each request produces exactly one slip.

The output stream cannot be paused, so the output has a valid strobe and no ready input. A consumer must take each word during the valid cycle; the word then stays on the output until the next valid. The mode input is meant to be changed only while reset is asserted.

Top module: `bit_deser`

## Requirements
- R1: A synchronous active-high reset clears the captured history, the bit counter, the slip offset, the slip lockout and the output. While reset is high and in the first cycle after it is released, `word_o` is 0 and `word_valid_o` is 0.
- R2: With `ddr_mode`=0, each cycle with `ce`=1 accepts one bit from `din[1]`. Eight accepted bits form a word. The first bit received lands in `word_o[7]` and the last in `word_o[0]`.
- R3: With `ddr_mode`=1, each cycle with `ce`=1 accepts two bits: `din[1]` is the earlier bit and `din[0]` the later. Four such cycles form a word, again with the earliest bit in `word_o[7]`.
- R4: A cycle with `ce`=0 accepts no bits, whatever `din` holds, and cannot complete a word.
- R5: `word_valid_o` is high for exactly one cycle per completed word, in the cycle after the edge that accepted the word's last bit. It is never high in two consecutive cycles. `word_o` is unchanged in every cycle where `word_valid_o` is low.
- R6: `bitslip` is sampled only at the edge that completes a word. A high level in any other cycle has no effect.
- R7: With `ddr_mode`=0, an accepted slip rotates the output of a repeating 8-bit pattern left by one bit. The word completed at the request edge is unchanged. The shift shows from the next word on.
- R8: With `ddr_mode`=1, accepted slips alternate after reset. The first slip rotates the output left by one; the next rotates it right by three; the pattern then repeats. Eight slips visit all eight rotations of a repeating pattern in the order 1,6,7,4,5,2,3,0 (left-rotation amounts).
- R9: After an accepted slip, `bitslip` is ignored at the next two word-completion edges. It is accepted again from the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ddr_mode | input | 1 | 1: two bits per cycle, 0: one bit per cycle |
| ce | input | 1 | Capture enable |
| din | input | 2 | Serial lane; bit 1 earlier, bit 0 used only in double-rate mode |
| bitslip | input | 1 | Word-boundary slip request |
| word_o | output | 8 | Parallel word, earliest bit in the MSB |
| word_valid_o | output | 1 | One-cycle strobe per new word |

## Verification
The bench builds the block with its default parameters: an 8-bit word, a double-rate back-step of three bits and a two-word slip lockout. These values make the full rotation cycle short, so eight slips in each mode reach every rotation of one 8-bit training pattern. The lockout can be crossed within four word periods, which shows one held request giving exactly two slips. Random streams, with and without enable gaps, exercise capture order in both rates. A slip level held only on non-completing cycles shows that those samples are ignored.

// File: rtl/deser_pkg.sv
`timescale 1ns/1ps
package deser_pkg;

  // Which step the next double-rate slip applies.
  typedef enum logic {
    SLIP_FINE   = 1'b0,  // move boundary one bit later
    SLIP_COARSE = 1'b1   // move boundary back by the configured step
  } slip_phase_e;

  // Rate selection as seen by the capture stage.
  typedef enum logic {
    RATE_SINGLE = 1'b0,
    RATE_DOUBLE = 1'b1
  } rate_e;

endpackage

// File: rtl/deser_capture.sv
`timescale 1ns/1ps
module deser_capture
  import deser_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ce,
  input  rate_e                 rate,
  input  logic [1:0]            din,
  output logic [2*WORD_W-2:0]   hist_next,
  output logic                  word_done
);

  localparam int HIST_W = 2 * WORD_W - 1;
  localparam int CNT_W  = $clog2(WORD_W) + 1;

  logic [HIST_W-1:0] hist_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  step;
  logic [CNT_W-1:0]  sum;

  // Newest bit always enters at index 0; older bits move up.
  always_comb begin
    if (rate == RATE_DOUBLE) begin
      hist_next = {hist_q[HIST_W-3:0], din[1], din[0]};
      step      = CNT_W'(2);
    end else begin
      hist_next = {hist_q[HIST_W-2:0], din[1]};
      step      = CNT_W'(1);
    end
    sum       = cnt_q + step;
    word_done = ce && (sum >= CNT_W'(WORD_W));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= '0;
      cnt_q  <= '0;
    end else if (ce) begin
      hist_q <= hist_next;
      cnt_q  <= word_done ? (sum - CNT_W'(WORD_W)) : sum;
    end
  end

endmodule

// File: rtl/deser_slip.sv
`timescale 1ns/1ps
module deser_slip
  import deser_pkg::*;
#(
  parameter int WORD_W    = 8,
  parameter int DDR_BACK  = 3,
  parameter int SLIP_LOCK = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      word_done,
  input  logic                      bitslip,
  input  rate_e                     rate,
  output logic [$clog2(WORD_W)-1:0] slip_idx,
  output logic                      slip_take
);

  localparam int IDX_W  = $clog2(WORD_W);
  localparam int LOCK_W = $clog2(SLIP_LOCK + 1);

  slip_phase_e        phase_q;
  logic [LOCK_W-1:0]  lock_q;
  logic [IDX_W-1:0]   idx_q;
  logic [IDX_W-1:0]   idx_dec;
  logic [IDX_W-1:0]   idx_back;
  logic [IDX_W:0]     idx_up;
  logic [IDX_W-1:0]   idx_new;
  slip_phase_e        phase_new;

  assign slip_take = word_done && bitslip && (lock_q == '0);
  assign slip_idx  = idx_q;

  // Window offset arithmetic modulo the word width.
  always_comb begin
    idx_dec  = (idx_q == '0) ? IDX_W'(WORD_W - 1) : (idx_q - IDX_W'(1));
    idx_up   = {1'b0, idx_q} + (IDX_W+1)'(DDR_BACK);
    idx_back = (idx_up >= (IDX_W+1)'(WORD_W)) ?
               IDX_W'(idx_up - (IDX_W+1)'(WORD_W)) : idx_up[IDX_W-1:0];
    idx_new   = idx_dec;
    phase_new = phase_q;
    if (rate == RATE_DOUBLE) begin
      if (phase_q == SLIP_FINE) begin
        idx_new   = idx_dec;
        phase_new = SLIP_COARSE;
      end else begin
        idx_new   = idx_back;
        phase_new = SLIP_FINE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q   <= '0;
      phase_q <= SLIP_FINE;
      lock_q  <= '0;
    end else if (slip_take) begin
      idx_q   <= idx_new;
      phase_q <= phase_new;
      lock_q  <= LOCK_W'(SLIP_LOCK);
    end else if (word_done && (lock_q != '0)) begin
      lock_q  <= lock_q - LOCK_W'(1);
    end
  end

endmodule

// File: rtl/deser_outreg.sv
`timescale 1ns/1ps
module deser_outreg #(
  parameter int WORD_W = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      word_done,
  input  logic [2*WORD_W-2:0]       hist_next,
  input  logic [$clog2(WORD_W)-1:0] slip_idx,
  output logic [WORD_W-1:0]         word_o,
  output logic                      word_valid_o
);

  logic [WORD_W-1:0] win [WORD_W];

  // One candidate window per boundary offset; offset g reaches g bits back.
  for (genvar g = 0; g < WORD_W; g++) begin : g_win
    assign win[g] = hist_next[WORD_W-1+g -: WORD_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word_o       <= '0;
      word_valid_o <= 1'b0;
    end else begin
      word_valid_o <= word_done;
      if (word_done) word_o <= win[slip_idx];
    end
  end

endmodule

// File: rtl/bit_deser.sv
`timescale 1ns/1ps
module bit_deser
  import deser_pkg::*;
#(
  parameter int WORD_W    = 8,
  parameter int DDR_BACK  = 3,
  parameter int SLIP_LOCK = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ddr_mode,
  input  logic              ce,
  input  logic [1:0]        din,
  input  logic              bitslip,
  output logic [WORD_W-1:0] word_o,
  output logic              word_valid_o
);

  localparam int HIST_W = 2 * WORD_W - 1;
  localparam int IDX_W  = $clog2(WORD_W);

  rate_e              rate;
  logic [HIST_W-1:0]  hist_next;
  logic               word_done;
  logic [IDX_W-1:0]   slip_idx;
  logic               slip_take;

  assign rate = ddr_mode ? RATE_DOUBLE : RATE_SINGLE;

  deser_capture #(.WORD_W(WORD_W)) u_cap (
    .clk       (clk),
    .rst       (rst),
    .ce        (ce),
    .rate      (rate),
    .din       (din),
    .hist_next (hist_next),
    .word_done (word_done)
  );

  deser_slip #(
    .WORD_W    (WORD_W),
    .DDR_BACK  (DDR_BACK),
    .SLIP_LOCK (SLIP_LOCK)
  ) u_slip (
    .clk       (clk),
    .rst       (rst),
    .word_done (word_done),
    .bitslip   (bitslip),
    .rate      (rate),
    .slip_idx  (slip_idx),
    .slip_take (slip_take)
  );

  deser_outreg #(.WORD_W(WORD_W)) u_out (
    .clk          (clk),
    .rst          (rst),
    .word_done    (word_done),
    .hist_next    (hist_next),
    .slip_idx     (slip_idx),
    .word_o       (word_o),
    .word_valid_o (word_valid_o)
  );

endmodule

// File: rtl/bit_deser_chk.sv
`timescale 1ns/1ps
module bit_deser_chk #(
  parameter int WORD_W    = 8,
  parameter int SLIP_LOCK = 2
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      ce,
  input logic [WORD_W-1:0]         word_o,
  input logic                      word_valid_o,
  input logic                      word_done,
  input logic                      slip_take,
  input logic [$clog2(WORD_W)-1:0] slip_idx
);

  localparam int GAP_W = $clog2(SLIP_LOCK + 1) + 1;

  // Word edges seen since the last accepted slip, saturating.
  logic [GAP_W-1:0] since_take;

  always_ff @(posedge clk) begin
    if (rst) since_take <= GAP_W'(SLIP_LOCK);
    else if (slip_take) since_take <= '0;
    else if (word_done && (since_take < GAP_W'(SLIP_LOCK))) since_take <= since_take + GAP_W'(1);
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (word_o == '0) && !word_valid_o);                      // R1

  AST_CE_GATE: assert property (@(posedge clk) disable iff (rst)
    !ce |=> !word_valid_o);                                               // R4

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    word_valid_o |=> !word_valid_o);                                      // R5

  AST_HOLD_WORD: assert property (@(posedge clk) disable iff (rst)
    !word_valid_o && !$fell(rst) |-> $stable(word_o));                    // R5

  AST_SLIP_AT_WORD: assert property (@(posedge clk) disable iff (rst)
    !$stable(slip_idx) |-> word_valid_o);                                 // R6

  AST_SLIP_LOCKOUT: assert property (@(posedge clk) disable iff (rst)
    slip_take |-> since_take >= GAP_W'(SLIP_LOCK));                       // R9

endmodule

bind bit_deser bit_deser_chk #(.WORD_W(WORD_W), .SLIP_LOCK(SLIP_LOCK)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .ce           (ce),
  .word_o       (word_o),
  .word_valid_o (word_valid_o),
  .word_done    (word_done),
  .slip_take    (slip_take),
  .slip_idx     (slip_idx)
);

// File: tb/bit_deser_tb_top.sv
`timescale 1ns/1ps
module bit_deser_tb_top;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         ddr_mode = 1'b0;
  logic         ce = 1'b0;
  logic [1:0]   din = 2'b00;
  logic         bitslip = 1'b0;
  logic [W-1:0] word_o;
  logic         word_valid_o;

  always #2.5 clk = ~clk;

  bit_deser dut_i (
    .clk(clk), .rst(rst), .ddr_mode(ddr_mode), .ce(ce), .din(din),
    .bitslip(bitslip), .word_o(word_o), .word_valid_o(word_valid_o)
  );

  int checks = 0;
  int bad = 0;

  // Reference model state, built from the requirements.
  logic [2*W-2:0] m_hist;
  int             m_cnt, m_j, m_lock;
  bit             m_ph;
  logic [W-1:0]   exp_q[$];
  string          tag_q[$];
  string          cur_tag = "R2";
  logic [W-1:0]   pat = 8'h17;
  int             pat_pos = 0;
  bit             use_pat = 0;
  logic [W-1:0]   last_word, prev_w;

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [W-1:0] rotl(input logic [W-1:0] p, input int k);
    logic [2*W-1:0] t;
    t = {p, p} << k;
    return t[2*W-1:W];
  endfunction

  function automatic bit next_bit();
    bit b;
    if (use_pat) begin
      b = pat[W-1-pat_pos];
      pat_pos = (pat_pos + 1) % W;
    end else b = 1'($urandom_range(0, 1));
    return b;
  endfunction

  // sl: 0 none, 1 only on the word edge, 2 held, 3 only off the word edge
  task automatic cyc(input bit e, input int sl, output bit tk);
    bit b1, b0, s;
    int step;
    @(negedge clk);
    step = ddr_mode ? 2 : 1;
    tk = e && (m_cnt + step >= W);
    if (e) begin
      b1 = next_bit();
      b0 = ddr_mode ? next_bit() : 1'($urandom_range(0, 1));
    end else begin
      b1 = 1'($urandom_range(0, 1));
      b0 = 1'($urandom_range(0, 1));
    end
    case (sl)
      1: s = tk;
      2: s = 1'b1;
      3: s = !tk;
      default: s = 1'b0;
    endcase
    din = {b1, b0}; ce = e; bitslip = s;
    if (e) begin
      m_hist = ddr_mode ? {m_hist[2*W-4:0], b1, b0} : {m_hist[2*W-3:0], b1};
      m_cnt  = m_cnt + step - (tk ? W : 0);
    end
    if (tk) begin
      exp_q.push_back(m_hist[W-1+m_j -: W]);
      tag_q.push_back(cur_tag);
      if (s && m_lock == 0) begin
        if (!ddr_mode || !m_ph) m_j = (m_j + W - 1) % W;
        else m_j = (m_j + 3) % W;
        if (ddr_mode) m_ph = !m_ph;
        m_lock = 2;
      end else if (m_lock > 0) m_lock--;
    end
  endtask

  task automatic run_words(input int n, input int sl, input bit gap);
    int got = 0;
    int c = 0;
    bit tk;
    while (got < n) begin
      cyc(!(gap && (c % 3 == 2)), sl, tk);
      c++;
      if (tk) got++;
    end
  endtask

  task automatic idle(input int n);
    bit tk;
    for (int i = 0; i < n; i++) cyc(1'b0, 0, tk);
  endtask

  task automatic do_reset(input bit mode);
    @(negedge clk);
    rst = 1'b1; ce = 1'b0; bitslip = 1'b0; ddr_mode = mode;
    repeat (3) @(negedge clk);
    m_hist = '0; m_cnt = 0; m_j = 0; m_lock = 0; m_ph = 0; pat_pos = 0;
    rst = 1'b0;
    @(negedge clk);
    chk(word_o == '0 && !word_valid_o, "R1", word_o, '0);
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst) prev_w = '0;
    else begin
      if (word_valid_o) begin
        if (exp_q.size() == 0) chk(1'b0, "R5 unexpected word", word_o, '0);
        else begin
          logic [W-1:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(word_o === e, t, word_o, e);
        end
        last_word = word_o;
      end else chk(word_o === prev_w, "R5 hold", word_o, prev_w);
      prev_w = word_o;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", '0, '0);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    int kseq [8] = '{1, 6, 7, 4, 5, 2, 3, 0};
    logic [W-1:0] seen;
    m_hist = '0; m_cnt = 0; m_j = 0; m_lock = 0; m_ph = 0;

    // Single rate: random capture order (R2), enable gaps (R4)
    do_reset(1'b0);
    use_pat = 0; cur_tag = "R2"; run_words(6, 0, 0); idle(3);
    cur_tag = "R4"; run_words(6, 0, 1); idle(3);

    // Single-rate slips on a training pattern (R7)
    do_reset(1'b0);
    use_pat = 1; cur_tag = "R2"; run_words(1, 0, 0); idle(3);
    chk(last_word == pat, "R2 first bit in MSB", last_word, pat);
    cur_tag = "R7";
    for (int i = 1; i <= 8; i++) begin
      run_words(1, 1, 0); run_words(2, 0, 0); idle(3);
      chk(last_word == rotl(pat, i % 8), "R7", last_word, rotl(pat, i % 8));
    end
    // Slip level only off the word edge is ignored (R6)
    cur_tag = "R6"; run_words(4, 3, 0); idle(3);
    chk(last_word == pat, "R6", last_word, pat);
    // Held request: lockout (R9)
    cur_tag = "R9"; run_words(3, 2, 0); idle(3);
    chk(last_word == rotl(pat, 1), "R9 one slip", last_word, rotl(pat, 1));
    run_words(4, 2, 0); run_words(1, 0, 0); idle(3);
    chk(last_word == rotl(pat, 3), "R9 two slips", last_word, rotl(pat, 3));

    // Double rate: random order (R3), gaps (R4)
    do_reset(1'b1);
    use_pat = 0; cur_tag = "R3"; run_words(6, 0, 0); idle(3);
    cur_tag = "R4"; run_words(4, 0, 1); idle(3);

    // Double-rate slips visit every rotation (R8)
    do_reset(1'b1);
    use_pat = 1; cur_tag = "R3"; run_words(1, 0, 0); idle(3);
    chk(last_word == pat, "R3 pair order", last_word, pat);
    cur_tag = "R8"; seen = '0;
    for (int i = 0; i < 8; i++) begin
      run_words(1, 1, 0); run_words(2, 0, 0); idle(3);
      chk(last_word == rotl(pat, kseq[i]), "R8", last_word, rotl(pat, kseq[i]));
      for (int r = 0; r < 8; r++) if (rotl(pat, r) == last_word) seen[r] = 1'b1;
    end
    chk(seen == 8'hFF, "R8 all rotations", seen, 8'hFF);

    idle(3);
    chk(exp_q.size() == 0, "R5 missing words", 8'(exp_q.size()), '0);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule